// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style datapath. It takes two 8-bit operands: one from the accumulator and one from a temporary holding register. A 3-bit operation code selects one of eight operations. When the execute strobe is high on a rising clock edge, the block registers the result for write-back to the accumulator, raises a one-cycle write enable and updates an internal five-flag status register. The status register is presented as a packed byte.

The flags give the sign, zero, nibble carry, even parity and carry/borrow of the most recent executed operation. Between operations the flags do not change. The add-with-carry and subtract-with-borrow operations take their extra input from the stored carry flag, so multi-byte arithmetic can be chained over successive strobes. Compare runs a subtraction only for its flags and leaves the accumulator alone.

Top module: `alu8_core`

## Requirements
- R1: Op 000 (add) gives A+B and op 001 (add with carry) gives A+B+CY, both modulo 256, where CY is the stored carry flag. The result appears on `acc_o` one clock after the strobe.
- R2: Op 010 (subtract) gives A-B and op 011 (subtract with borrow) gives A-B-CY, both modulo 256.
- R3: After an add, CY (flag bit 0) is the carry out of bit 7. After a subtract or compare, CY is 1 when a borrow occurred, that is when B plus the borrow-in exceeds A.
- R4: AC (flag bit 4) is the carry out of bit 3. For subtraction it is the carry out of bit 3 of the sum A + ~B + (1 - borrow-in).
- R5: S (flag bit 7) equals bit 7 of the 8-bit result.
- R6: Z (flag bit 6) is 1 exactly when the 8-bit result is zero.
- R7: P (flag bit 2) is 1 when the result has an even number of ones and 0 when the count is odd.
- R8: Op 100 gives A AND B, op 101 gives A XOR B and op 110 gives A OR B. All three clear CY. AND sets AC, while XOR and OR clear it.
- R9: Op 111 (compare) updates the flags as a subtraction A-B would. It leaves `wr_en_o` low and `acc_o` unchanged.
- R10: In the flag byte, bit 1 reads 1 and bits 5 and 3 read 0 at all times.
- R11: While the execute strobe is low, the flags and `acc_o` hold their values and `wr_en_o` is 0.
- R12: Synchronous reset gives a flag byte of 8'h02, an `acc_o` of 0 and a `wr_en_o` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe; one operation per high cycle |
| op_i | input | 3 | Operation select |
| acc_i | input | 8 | Accumulator operand (A) |
| tmp_i | input | 8 | Temporary-register operand (B) |
| acc_o | output | 8 | Registered result for the accumulator |
| wr_en_o | output | 1 | One-cycle write-back enable |
| flags_o | output | 8 | Packed status byte |

## Verification
The assertions assume that the operation select and both operands are valid (not X) in every cycle where the strobe is high. They also assume that reset is held for at least one edge before the first operation. The bench drives every input on the falling edge to a defined value, even in idle cycles. It holds reset for several cycles before it issues any strobe, and it mixes idle gaps between operations so the hold behaviour is checked as well.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 8;

  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_AC = 4;
  localparam int F_P  = 2;
  localparam int F_CY = 0;
  localparam int F_ONE = 1;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_ADC = 3'b001,
    OP_SUB = 3'b010,
    OP_SBB = 3'b011,
    OP_AND = 3'b100,
    OP_XOR = 3'b101,
    OP_OR  = 3'b110,
    OP_CMP = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o
);
  localparam int HW = W - NW;

  logic [W-1:0]  b_eff;
  logic          c0;
  logic [NW:0]   lo_sum;
  logic [HW:0]   hi_sum;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    c0     = sub_i ? ~cin_i : cin_i;
    lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c0};
    hi_sum = {1'b0, a_i[W-1:NW]} + {1'b0, b_eff[W-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
    res_o  = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
    ac_o   = lo_sum[NW];
    cy_o   = sub_i ? ~hi_sum[HW] : hi_sum[HW];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         ac_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
    ac_o = (sel_i == 2'b00);
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] res_i,
  input  logic         ac_i,
  input  logic         cy_i,
  output flag_set_t    flags_o
);
  always_comb begin
    flags_o.s  = res_i[W-1];
    flags_o.z  = (res_i == '0);
    flags_o.ac = ac_i;
    flags_o.p  = ~^res_i;
    flags_o.cy = cy_i;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] tmp_i,
  output logic [W-1:0] acc_o,
  output logic         wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e     op;
  logic        is_logic, is_sub, use_cy, is_cmp;
  logic [W-1:0] ar_res, lg_res, res;
  logic        ar_cy, ar_ac, lg_ac, nxt_cy, nxt_ac;
  flag_set_t   nxt_flags, flag_q;

  assign op       = alu_op_e'(op_i);
  assign is_cmp   = (op == OP_CMP);
  assign is_logic = op_i[2] && !is_cmp;
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || is_cmp;
  assign use_cy   = (op == OP_ADC) || (op == OP_SBB);

  alu8_arith #(.W(W)) u_arith (
    .a_i(acc_i), .b_i(tmp_i), .sub_i(is_sub), .cin_i(use_cy & flag_q.cy),
    .res_o(ar_res), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(tmp_i), .sel_i(op_i[1:0]),
    .res_o(lg_res), .ac_o(lg_ac)
  );

  always_comb begin
    res    = is_logic ? lg_res : ar_res;
    nxt_cy = is_logic ? 1'b0   : ar_cy;
    nxt_ac = is_logic ? lg_ac  : ar_ac;
  end

  alu8_flags #(.W(W)) u_flags (
    .res_i(res), .ac_i(nxt_ac), .cy_i(nxt_cy), .flags_o(nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      acc_o   <= '0;
      wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= exec_i && !is_cmp;
      if (exec_i) begin
        flag_q <= nxt_flags;
        if (!is_cmp) acc_o <= res;
      end
    end
  end

  always_comb begin
    flags_o        = '0;
    flags_o[F_S]   = flag_q.s;
    flags_o[F_Z]   = flag_q.z;
    flags_o[F_AC]  = flag_q.ac;
    flags_o[F_P]   = flag_q.p;
    flags_o[F_CY]  = flag_q.cy;
    flags_o[F_ONE] = 1'b1;
  end

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'b111) |=> (!wr_en_o && $stable(acc_o)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> ($stable(flags_o) && $stable(acc_o) && !wr_en_o));
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (flags_o[F_Z] == (acc_o == '0)));
  // R7
  parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (flags_o[F_P] == ~^acc_o));
  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (flags_o[F_S] == acc_o[W-1]));
  // R8
  logic_clears_cy_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i[2] && op_i != 3'b111) |=> !flags_o[F_CY]);
endmodule

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] acc_i = 8'd0;
  logic [7:0] tmp_i = 8'd0;
  logic [7:0] acc_o;
  logic       wr_en_o;
  logic [7:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_acc, m_we, m_s, m_z, m_ac, m_p, m_cy;

  always #10 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i),
    .acc_i(acc_i), .tmp_i(tmp_i),
    .acc_o(acc_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2 acc_o", acc_o, m_acc);
    chk("R9/R11 wr_en_o", wr_en_o, m_we);
    chk("R5 sign", flags_o[7], m_s);
    chk("R6 zero", flags_o[6], m_z);
    chk("R4 aux carry", flags_o[4], m_ac);
    chk("R7 parity", flags_o[2], m_p);
    chk("R3 carry", flags_o[0], m_cy);
    chk("R10 fixed bits", {flags_o[5], flags_o[3], flags_o[1]}, 3'b001);
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic model(input bit r, input bit e, input int op, input int a, input int b);
    int res, cin, ac, cy;
    if (r) begin
      m_acc = 0; m_we = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
      return;
    end
    m_we = (e && op != 7) ? 1 : 0;
    if (!e) return;
    cin = (op == 1 || op == 3) ? m_cy : 0;
    case (op)
      0, 1: begin
        res = a + b + cin;
        cy  = (res > 255) ? 1 : 0;
        ac  = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
      end
      2, 3, 7: begin
        res = a - b - cin;
        cy  = (b + cin > a) ? 1 : 0;
        ac  = (((a & 15) + ((~b) & 15) + (1 - cin)) > 15) ? 1 : 0;
      end
      4: begin res = a & b; cy = 0; ac = 1; end
      5: begin res = a ^ b; cy = 0; ac = 0; end
      default: begin res = a | b; cy = 0; ac = 0; end
    endcase
    res &= 255;
    if (op != 7) m_acc = res;
    m_s = (res >> 7) & 1;
    m_z = (res == 0) ? 1 : 0;
    m_p = (ones(res) % 2 == 0) ? 1 : 0;
    m_ac = ac;
    m_cy = cy;
  endtask

  task automatic step(input bit r, input bit e, input int op, input int a, input int b);
    @(negedge clk);
    compare_all();
    rst = r; exec_i = e; op_i = op[2:0]; acc_i = a[7:0]; tmp_i = b[7:0];
    model(r, e, op, a, b);
  endtask

  initial begin
    m_acc = 0; m_we = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    @(negedge clk);
    model(1, 0, 0, 0, 0);
    repeat (3) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);            // R12 reset state observed
    step(0, 1, 0, 8'hFF, 8'h01);    // R1 R3 R4 R6: wrap to zero
    step(0, 1, 1, 8'h10, 8'h20);    // R1 adc with CY=1
    step(0, 1, 2, 8'h00, 8'h01);    // R2 R3 borrow, R5 sign
    step(0, 1, 3, 8'h05, 8'h05);    // R2 sbb with borrow-in
    step(0, 0, 4, 8'h12, 8'h34);    // R11 idle
    step(0, 0, 5, 8'h99, 8'h66);    // R11 idle
    step(0, 1, 4, 8'hF0, 8'h3C);    // R8 and sets AC
    step(0, 1, 5, 8'hAA, 8'hAA);    // R8 xor -> zero
    step(0, 1, 6, 8'h81, 8'h02);    // R8 or
    step(0, 1, 7, 8'h40, 8'h40);    // R9 compare equal
    step(0, 1, 7, 8'h10, 8'h20);    // R9 compare borrow
    step(0, 1, 0, 8'h08, 8'h08);    // R4 nibble carry
    step(0, 1, 2, 8'h10, 8'h01);    // R4 nibble borrow
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      int a = (i % 3 == 0) ? m_acc : $urandom_range(0, 255);
      step(0, ($urandom_range(0, 3) != 0), op, a, $urandom_range(0, 255));
    end
    step(1, 1, 0, 8'h11, 8'h22);    // R12 reset overrides strobe
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule